// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Path

This block collects level-sensitive interrupt lines from peripherals and presents them to a processor core. Each maskable line sets a pending bit. The pending bits are ANDed with a software-written enable word, and the result is encoded onto an 8-bit vector bus with an accompanying request wire. When exactly one enabled source is pending, the vector identifies that source. When several are pending together, a single shared vector is presented and software decides which one to service first. The upper lines bypass the mask entirely and feed a non-maskable interrupt output.

Software sees five 32-bit words through a word-addressed bus with byte enables. Only the enable word can be written. The other words are read-only views of the raw pending bits, the enabled pending bits and the non-maskable status, plus one word that always reads as zero. Line inputs and mask writes are sampled on the same clock edge, and the vector, request and non-maskable outputs present the new state from that edge on.

Top module: `vec_intc`

## Requirements
- R1: While reset is asserted and after it is released, the mask, raw pending and non-maskable status words read as zero, and cpu_vec, cpu_irq and cpu_nmi are low.
- R2: A write changes the mask only when bus_addr is 0 and bus_be is 4'hF. A write to any other address, or one with any byte enable low, leaves the mask unchanged.
- R3: A read with bus_be 4'hF returns the mask at address 0, the raw pending word at address 1, the enabled pending word at address 2 and the non-maskable status at address 3. Addresses 4 to 7 read zero, and a read with any byte enable low returns zero.
- R4: The enabled pending word always equals the raw pending word ANDed bitwise with the mask.
- R5: When exactly one enabled pending bit i is set, cpu_vec equals 8'h31 + i.
- R6: When two or more enabled pending bits are set, cpu_vec equals 8'h30.
- R7: When no enabled pending bit is set, cpu_vec is 8'h00. cpu_irq is high exactly when cpu_vec is non-zero.
- R8: Line n, for n from 1 to 29, drives raw pending bit n-1 and follows its level both when it rises and when it falls. Raw pending bits 29 to 31 are always zero.
- R9: Line n, for n of 30 or more, drives non-maskable status bit n. It never sets a raw pending bit and never changes cpu_vec or cpu_irq.
- R10: cpu_nmi is high whenever any non-maskable status bit is set, whatever the mask holds.
- R11: A line change or a mask write applied before a rising clock edge appears on cpu_vec, cpu_irq and cpu_nmi right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 31 | Level interrupt lines, indexed 31 down to 1 |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | High for write, low for read |
| bus_addr | input | 3 | Word address |
| bus_be | input | 4 | Byte enables, all four required |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| cpu_vec | output | 8 | Interrupt vector to the core |
| cpu_irq | output | 1 | Maskable interrupt request to the core |
| cpu_nmi | output | 1 | Non-maskable interrupt to the core |

## Verification
A mask write and a change on the interrupt lines can land on the same clock edge, and both feed the vector encoder. Every row of the stimulus table drives a new line pattern and a new mask value in the same cycle, so the encoder must combine the new raw bits with the new mask, not either old value. The bench reads the request, vector and non-maskable outputs in the next low clock phase and compares them with hand-computed expectations that follow the single, shared and idle vector rules. A directed step confirms that nothing moves before the sampling edge.

// File: rtl/vec_intc_pkg.sv
`timescale 1ns/1ps
package vec_intc_pkg;

   // Word offsets of the register window; decode depends on these values
   typedef enum logic [2:0] {
      OFS_MASK   = 3'd0,
      OFS_RAW    = 3'd1,
      OFS_MASKED = 3'd2,
      OFS_NMI    = 3'd3,
      OFS_RSVD   = 3'd4
   } reg_ofs_e;

   localparam int unsigned REG_COUNT = 5;

endpackage

// File: rtl/vec_intc_route.sv
`timescale 1ns/1ps
module vec_intc_route #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned NMI_BASE  = 30,
   parameter int unsigned WORD_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:1] lines,
   output logic [WORD_W-1:0]    raw_d,
   output logic [WORD_W-1:0]    raw_q,
   output logic [WORD_W-1:0]    nmi_d,
   output logic [WORD_W-1:0]    nmi_q
);

   // Each line lands either one bit down in the maskable word or
   // at its own index in the non-maskable word
   for (genvar n = 1; n < NUM_LINES; n++) begin : g_line
      if (n < NMI_BASE) begin : g_maskable
         assign raw_d[n-1] = lines[n];
      end else begin : g_nonmask
         assign nmi_d[n] = lines[n];
      end
   end

   assign raw_d[WORD_W-1:NMI_BASE-1] = '0;
   assign nmi_d[NMI_BASE-1:0]        = '0;

   if (NUM_LINES < WORD_W) begin : g_nmi_pad
      assign nmi_d[WORD_W-1:NUM_LINES] = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
         nmi_q <= '0;
      end else begin
         raw_q <= raw_d;
         nmi_q <= nmi_d;
      end
   end

endmodule

// File: rtl/vec_intc_regs.sv
`timescale 1ns/1ps
module vec_intc_regs
   import vec_intc_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned BE_W   = WORD_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BE_W-1:0]   bus_be,
   input  logic [WORD_W-1:0] bus_wdata,
   input  logic [WORD_W-1:0] raw_q,
   input  logic [WORD_W-1:0] nmi_q,
   output logic [WORD_W-1:0] mask_d,
   output logic [WORD_W-1:0] mask_q,
   output logic [WORD_W-1:0] bus_rdata
);

   localparam logic [BE_W-1:0] FULL_BE = {BE_W{1'b1}};

   logic full_word;
   logic mask_wr;
   logic rd_ok;

   assign full_word = (bus_be == FULL_BE);
   assign mask_wr   = bus_en && bus_we && full_word &&
                      (bus_addr == ADDR_W'(OFS_MASK));
   assign rd_ok     = bus_en && !bus_we && full_word;

   assign mask_d = mask_wr ? bus_wdata : mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_ok) begin
         case (bus_addr)
            ADDR_W'(OFS_MASK):   bus_rdata = mask_q;
            ADDR_W'(OFS_RAW):    bus_rdata = raw_q;
            ADDR_W'(OFS_MASKED): bus_rdata = raw_q & mask_q;
            ADDR_W'(OFS_NMI):    bus_rdata = nmi_q;
            ADDR_W'(OFS_RSVD):   bus_rdata = '0;
            default:             bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/vec_intc_encode.sv
`timescale 1ns/1ps
module vec_intc_encode #(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VEC_SHARED = 8'h30,
   parameter int unsigned VEC_BASE   = 8'h31
) (
   input  logic [WORD_W-1:0] enabled,
   output logic [VEC_W-1:0]  vec
);

   localparam int unsigned IDX_W = $clog2(WORD_W);

   if (VEC_BASE + WORD_W - 1 >= (1 << VEC_W)) begin : g_bad_range
      $error("vec_intc_encode: vector range exceeds VEC_W");
   end
   if (VEC_SHARED >= VEC_BASE || VEC_SHARED == 0) begin : g_bad_shared
      $error("vec_intc_encode: shared vector must be non-zero and below VEC_BASE");
   end

   logic [IDX_W-1:0]  low_idx;
   logic              several;
   logic [WORD_W-1:0] drop_low;

   // Clearing the lowest set bit leaves something only if two or more were set
   assign drop_low = enabled & (enabled - WORD_W'(1));
   assign several  = |drop_low;

   always_comb begin
      low_idx = '0;
      for (int i = WORD_W - 1; i >= 0; i--) begin
         if (enabled[i]) low_idx = i[IDX_W-1:0];
      end
   end

   always_comb begin
      if (enabled == '0)  vec = '0;
      else if (several)   vec = VEC_W'(VEC_SHARED);
      else                vec = VEC_W'(VEC_BASE) + VEC_W'(low_idx);
   end

endmodule

// File: rtl/vec_intc.sv
`timescale 1ns/1ps
module vec_intc #(
   parameter int unsigned NUM_LINES  = 32,
   parameter int unsigned NMI_BASE   = 30,
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VEC_SHARED = 8'h30,
   parameter int unsigned VEC_BASE   = 8'h31
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_LINES-1:1]   irq_lines,
   input  logic                   bus_en,
   input  logic                   bus_we,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [WORD_W/8-1:0]    bus_be,
   input  logic [WORD_W-1:0]      bus_wdata,
   output logic [WORD_W-1:0]      bus_rdata,
   output logic [VEC_W-1:0]       cpu_vec,
   output logic                   cpu_irq,
   output logic                   cpu_nmi
);

   localparam int unsigned BE_W = WORD_W / 8;

   if (NUM_LINES > WORD_W) begin : g_bad_lines
      $error("vec_intc: NUM_LINES must not exceed WORD_W");
   end
   if (NMI_BASE < 2 || NMI_BASE > NUM_LINES) begin : g_bad_nmi
      $error("vec_intc: NMI_BASE out of range");
   end
   if ((1 << ADDR_W) < vec_intc_pkg::REG_COUNT) begin : g_bad_addr
      $error("vec_intc: ADDR_W too small for the register window");
   end
   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("vec_intc: WORD_W must be a whole number of bytes");
   end

   logic [WORD_W-1:0] raw_d, raw_q;
   logic [WORD_W-1:0] nmi_d, nmi_q;
   logic [WORD_W-1:0] mask_d, mask_q;
   logic [VEC_W-1:0]  vec_d;
   logic [VEC_W-1:0]  vec_q;
   logic              irq_q;

   vec_intc_route #(
      .NUM_LINES(NUM_LINES),
      .NMI_BASE (NMI_BASE),
      .WORD_W   (WORD_W)
   ) u_route (
      .clk  (clk),
      .rst_n(rst_n),
      .lines(irq_lines),
      .raw_d(raw_d),
      .raw_q(raw_q),
      .nmi_d(nmi_d),
      .nmi_q(nmi_q)
   );

   vec_intc_regs #(
      .WORD_W(WORD_W),
      .ADDR_W(ADDR_W),
      .BE_W  (BE_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_en   (bus_en),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .bus_be   (bus_be),
      .bus_wdata(bus_wdata),
      .raw_q    (raw_q),
      .nmi_q    (nmi_q),
      .mask_d   (mask_d),
      .mask_q   (mask_q),
      .bus_rdata(bus_rdata)
   );

   // Encode from next-state values so the vector lands on the same edge
   // as the pending and mask registers it describes
   vec_intc_encode #(
      .WORD_W    (WORD_W),
      .VEC_W     (VEC_W),
      .VEC_SHARED(VEC_SHARED),
      .VEC_BASE  (VEC_BASE)
   ) u_encode (
      .enabled(raw_d & mask_d),
      .vec    (vec_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q <= '0;
         irq_q <= 1'b0;
      end else begin
         vec_q <= vec_d;
         irq_q <= (vec_d != '0);
      end
   end

   assign cpu_vec = vec_q;
   assign cpu_irq = irq_q;
   assign cpu_nmi = |nmi_q;

endmodule

// File: rtl/vec_intc_chk.sv
`timescale 1ns/1ps
module vec_intc_chk #(
   parameter int unsigned NUM_LINES  = 32,
   parameter int unsigned NMI_BASE   = 30,
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VEC_SHARED = 8'h30,
   parameter int unsigned VEC_BASE   = 8'h31
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:1] irq_lines,
   input logic                 bus_en,
   input logic                 bus_we,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [WORD_W/8-1:0]  bus_be,
   input logic [WORD_W-1:0]    mask_q,
   input logic [WORD_W-1:0]    raw_q,
   input logic [VEC_W-1:0]     cpu_vec,
   input logic                 cpu_irq,
   input logic                 cpu_nmi
);

   logic past_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_valid <= 1'b0;
      else        past_valid <= 1'b1;
   end

   a_r7_irq_iff_vec: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq == (cpu_vec != '0));

   a_r7_idle_vec: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(raw_q & mask_q) == 0) |-> (cpu_vec == '0));

   a_r6_shared_vec: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(raw_q & mask_q) > 1) |-> (cpu_vec == VEC_W'(VEC_SHARED)));

   a_r5_single_vec: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(raw_q & mask_q) == 1) |->
         (cpu_vec >= VEC_W'(VEC_BASE) && cpu_irq));

   a_r2_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && (bus_addr != '0 || bus_be != '1)) |=> $stable(mask_q));

   a_r10_nmi_follows: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid |-> (cpu_nmi == $past(|irq_lines[NUM_LINES-1:NMI_BASE])));

endmodule

bind vec_intc vec_intc_chk #(
   .NUM_LINES (NUM_LINES),
   .NMI_BASE  (NMI_BASE),
   .WORD_W    (WORD_W),
   .ADDR_W    (ADDR_W),
   .VEC_W     (VEC_W),
   .VEC_SHARED(VEC_SHARED),
   .VEC_BASE  (VEC_BASE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_lines(irq_lines),
   .bus_en   (bus_en),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_be   (bus_be),
   .mask_q   (mask_q),
   .raw_q    (raw_q),
   .cpu_vec  (cpu_vec),
   .cpu_irq  (cpu_irq),
   .cpu_nmi  (cpu_nmi)
);

// File: tb/vec_intc_bench.sv
`timescale 1ns/1ps
module vec_intc_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:1] irq_lines = '0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  cpu_vec;
   logic        cpu_irq;
   logic        cpu_nmi;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   vec_intc u_vec_intc (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_lines(irq_lines),
      .bus_en   (bus_en),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .bus_be   (bus_be),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .cpu_vec  (cpu_vec),
      .cpu_irq  (cpu_irq),
      .cpu_nmi  (cpu_nmi)
   );

   // {line word (bit 0 unused), mask, expected vector, expected nmi}
   localparam int NROWS = 12;
   localparam logic [72:0] ROWS [NROWS] = '{
      {32'h0000_0002, 32'hFFFF_FFFF, 8'h31, 1'b0},
      {32'h2000_0000, 32'h1000_0000, 8'h4D, 1'b0},
      {32'h0000_0006, 32'hFFFF_FFFF, 8'h30, 1'b0},
      {32'h0000_0006, 32'h0000_0002, 8'h32, 1'b0},
      {32'h0000_0006, 32'h0000_0000, 8'h00, 1'b0},
      {32'h4000_0000, 32'hFFFF_FFFF, 8'h00, 1'b1},
      {32'h8000_0010, 32'hFFFF_FFFF, 8'h34, 1'b1},
      {32'h6000_0000, 32'hFFFF_FFFF, 8'h4D, 1'b1},
      {32'h0010_0000, 32'h0008_0000, 8'h44, 1'b0},
      {32'h3FFF_FFFE, 32'h0000_0001, 8'h31, 1'b0},
      {32'hC000_0000, 32'h0000_0000, 8'h00, 1'b1},
      {32'h0000_0000, 32'hFFFF_FFFF, 8'h00, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; bus_be = 4'h0;
   endtask

   task automatic read_check(input string req, input logic [2:0] a,
                             input logic [3:0] be, input logic [31:0] exp);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
      #0.5;
      check(req, bus_rdata, exp);
      bus_en = 1'b0; bus_be = 4'h0;
   endtask

   initial begin : watchdog
      #200000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] ln, mk, raw_exp;
      logic [7:0]  vx;
      logic        nx;
      string       vreq;

      // R1: reset state
      irq_lines = 31'h7FFF_FFFF;
      repeat (3) @(negedge clk);
      check("R1 vec in reset", 32'(cpu_vec), 32'h0);
      check("R1 irq in reset", 32'(cpu_irq), 32'h0);
      check("R1 nmi in reset", 32'(cpu_nmi), 32'h0);
      read_check("R1 mask in reset", 3'd0, 4'hF, 32'h0);
      irq_lines = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 vec after reset", 32'(cpu_vec), 32'h0);
      read_check("R1 raw after reset", 3'd1, 4'hF, 32'h0);
      read_check("R1 nmi word after reset", 3'd3, 4'hF, 32'h0);

      // Table: line pattern and mask write land on the same edge
      for (int r = 0; r < NROWS; r++) begin
         {ln, mk, vx, nx} = ROWS[r];
         raw_exp = {3'b000, ln[29:1]};
         @(negedge clk);
         irq_lines = ln[31:1];
         bus_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd0; bus_be = 4'hF; bus_wdata = mk;
         @(negedge clk);
         bus_en = 1'b0; bus_we = 1'b0; bus_be = 4'h0;
         vreq = (vx == 8'h00) ? "R7 vec idle" : (vx == 8'h30) ? "R6 vec shared" : "R5 vec single";
         check(vreq, 32'(cpu_vec), 32'(vx));
         check("R7 irq", 32'(cpu_irq), 32'(vx != 8'h00));
         check("R10 nmi out", 32'(cpu_nmi), 32'(nx));
         read_check("R2 mask readback", 3'd0, 4'hF, mk);
         read_check("R8 raw word", 3'd1, 4'hF, raw_exp);
         read_check("R4 masked word", 3'd2, 4'hF, raw_exp & mk);
         read_check("R9 nmi word", 3'd3, 4'hF, {ln[31:30], 30'h0});
      end

      // R2: writes elsewhere or partial are ignored
      bus_write(3'd0, 32'hA5A5_A5A5, 4'hF);
      bus_write(3'd1, 32'hFFFF_FFFF, 4'hF);
      bus_write(3'd2, 32'hFFFF_FFFF, 4'hF);
      bus_write(3'd3, 32'hFFFF_FFFF, 4'hF);
      bus_write(3'd4, 32'hFFFF_FFFF, 4'hF);
      bus_write(3'd0, 32'h0000_0000, 4'h3);
      read_check("R2 mask kept", 3'd0, 4'hF, 32'hA5A5_A5A5);
      read_check("R2 raw untouched by write", 3'd1, 4'hF, 32'h0);

      // R3: reserved and unmapped words, partial read
      read_check("R3 reserved word", 3'd4, 4'hF, 32'h0);
      read_check("R3 unmapped 5", 3'd5, 4'hF, 32'h0);
      read_check("R3 unmapped 7", 3'd7, 4'hF, 32'h0);
      read_check("R3 partial read", 3'd0, 4'h1, 32'h0);

      // R11: change held back until the edge; R8 falling level
      bus_write(3'd0, 32'hFFFF_FFFF, 4'hF);
      @(negedge clk);
      irq_lines = 31'h0000_0004;      // line 3 -> raw bit 2
      #0.5;
      check("R11 no change before edge", 32'(cpu_vec), 32'h0);
      @(posedge clk);
      #0.5;
      check("R11 vec after edge", 32'(cpu_vec), 32'h33);
      check("R11 irq after edge", 32'(cpu_irq), 32'h1);
      @(negedge clk);
      irq_lines = '0;
      @(negedge clk);
      check("R8 falling line clears vec", 32'(cpu_vec), 32'h0);
      read_check("R8 falling line clears raw", 3'd1, 4'hF, 32'h0);

      // R9: non-maskable line alone leaves maskable request low
      @(negedge clk);
      irq_lines = 31'h4000_0000;       // line 31
      @(negedge clk);
      check("R9 vec unaffected", 32'(cpu_vec), 32'h0);
      check("R9 irq unaffected", 32'(cpu_irq), 32'h0);
      check("R10 nmi set", 32'(cpu_nmi), 32'h1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule